// File: doc/BRIEF.md
# Maskable Interrupt Controller with Software Trap

This block arbitrates interrupt requests for a small 8-bit core. It collects external requests from groups of input pins and flag-style requests from peripherals. It applies one global mask bit, per-source enables and a selectable sensitivity for each external source. It also accepts a software trap that ignores the mask. A fixed priority order picks one source, and the block offers it to the core as a vector index paired with a valid signal. The core's entry strobe acts as ready. The core pulses an entry strobe when it begins servicing and a return strobe when it leaves the service routine. Stacking registers and fetching the vector stay in the core.

Each external source is the AND of its enabled pins, so a low level on any enabled pin holds the source line low. Each source can react to a low level, a falling edge, a rising edge or both edges. Edge requests are held in a latch until the core enters their routine. Peripheral flags persist until software clears them, either by a write of 0 or by reading the status and then accessing the data register. Both clears discard a request that is still pending. Two wake outputs serve the low-power modes: any enabled request wakes from WAIT, and only external requests wake from HALT.

The core side follows valid/ready rules. Once `irq_valid` rises, `irq_vec` does not change until `irq_ack` is seen in the same cycle as valid. A higher-priority arrival waits behind the offer. There is one exception: if the mask becomes set while a maskable vector is on offer, the offer is withdrawn. A trap offer is never withdrawn.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the global mask `irq_mask` is 1, `irq_valid` is 0, every peripheral flag is 0 and both wake outputs are 0.
- R2: A maskable request that becomes pending while the mask is set is not offered. It is offered once the mask is cleared through `mask_clr`.
- R3: Accepting an offer (`irq_valid` and `irq_ack` high together) drops `irq_valid` and sets the mask on the same edge. `irq_ret` or `mask_clr` clears the mask, and `mask_set` sets it.
- R4: A pulse on `trap_req` is offered as vector 0 whatever the mask state.
- R5: Priority is fixed. Vector 0 is the trap. Vectors 1 to N_EXT are external sources, with the lower index winning. Vectors N_EXT+1 onward are peripherals, again with the lower index winning.
- R6: An edge request latch clears when its vector is accepted, so it is not offered again. A level request is not latched and is offered again after return for as long as the line stays low.
- R7: The 2-bit field for external source i is `ext_sense[2i+1:2i]`. The codes are 00 for low level, 01 for falling edge, 10 for rising edge and 11 for both edges.
- R8: The line of external source i is the AND of its enabled pins `ext_pin[i*PINS_PER_EXT +: PINS_PER_EXT]`. While any enabled pin is low, edges on the other pins cannot produce a rising-edge request.
- R9: A peripheral is requested only while both its flag and its `per_en` bit are 1. A flag set while disabled stays pending and is offered when it is enabled.
- R10: A pulse on `per_wr0[k]` clears flag k and drops its pending request, unless `per_set[k]` fires in the same cycle.
- R11: A `per_data_acc[k]` pulse clears flag k only if a `per_stat_rd[k]` pulse arrived while the flag was set, with no data access in between. A data access on its own leaves the flag set.
- R12: `wake_wait` is 1 while any enabled request is pending. `wake_halt` is 1 only while an external request is pending.
- R13: While `irq_valid` is high and no acceptance occurs, `irq_vec` holds. If the mask is set while a nonzero vector is on offer, `irq_valid` falls on the next edge.
- R14: A request latched at clock edge k is offered at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Software trap pulse |
| ext_pin | input | N_EXT*PINS_PER_EXT | External pins, grouped per source |
| ext_pin_en | input | N_EXT*PINS_PER_EXT | Enable for each pin to take part in its source |
| ext_sense | input | 2*N_EXT | Sensitivity code for each external source |
| per_set | input | N_PER | Peripheral event pulse that sets a flag |
| per_en | input | N_PER | Interrupt enable for each peripheral |
| per_wr0 | input | N_PER | Write of 0 to a status bit |
| per_stat_rd | input | N_PER | Read of the status register |
| per_data_acc | input | N_PER | Access to the associated data register |
| per_flag | output | N_PER | Current peripheral flags |
| mask_set | input | 1 | Set the global mask |
| mask_clr | input | 1 | Clear the global mask |
| irq_valid | output | 1 | Vector offered to the core |
| irq_vec | output | VEC_W | Offered vector index |
| irq_ack | input | 1 | Entry strobe, acting as ready |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_mask | output | 1 | Global mask state |
| wake_wait | output | 1 | Wake request for WAIT mode |
| wake_halt | output | 1 | Wake request for HALT mode |

## Verification
Flags, edge latches, trap latches and the registered level state update on the edge that samples the stimulus. The wake outputs follow them straight after that edge, and the offer appears one edge later. Mask changes and acceptance show on the edge that samples the strobe. The mask drives the offer register, so an unmasked request reaches `irq_valid` one edge after `mask_clr` or `irq_ret`. A withdrawal follows `mask_set` after two edges. Every scenario drives its inputs just after a rising edge and reads the outputs 1 ns after the edge on which the count above says they change. Each scenario also checks the cycle before, so a result that arrives early is caught as well.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src
  import irq_pkg::*;
#(
  parameter int PINS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins,
  input  logic [PINS-1:0] pin_en,
  input  sense_e          sense,
  input  logic            clr,
  output logic            pend
);
  logic line, line_q, edge_q, hit;

  // Disabled pins read as high; any enabled low pin pulls the line low.
  assign line = &(pins | ~pin_en);

  always_comb begin
    unique case (sense)
      SENSE_FALL: hit = line_q & ~line;
      SENSE_RISE: hit = ~line_q & line;
      SENSE_BOTH: hit = line_q ^ line;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      line_q <= line;
      if (hit)                            edge_q <= 1'b1;
      else if (clr || sense == SENSE_LOW) edge_q <= 1'b0;
    end
  end

  assign pend = (sense == SENSE_LOW) ? ~line_q : edge_q;
endmodule

// File: rtl/irq_per_flag.sv
module irq_per_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr0,
  input  logic st_rd,
  input  logic dat_acc,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set)                   flag <= 1'b1;
      else if (wr0)              flag <= 1'b0;
      else if (dat_acc && armed) flag <= 1'b0;

      if (wr0 || dat_acc)        armed <= 1'b0;
      else if (st_rd && flag)    armed <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  // Lowest index wins: scan from the top so lower indices overwrite.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT        = 2,
  parameter int PINS_PER_EXT = 2,
  parameter int N_PER        = 4,
  localparam int N_SRC       = 1 + N_EXT + N_PER,
  localparam int VEC_W       = $clog2(N_SRC),
  localparam int N_PIN       = N_EXT * PINS_PER_EXT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic [N_PIN-1:0]   ext_pin,
  input  logic [N_PIN-1:0]   ext_pin_en,
  input  logic [2*N_EXT-1:0] ext_sense,
  input  logic [N_PER-1:0]   per_set,
  input  logic [N_PER-1:0]   per_en,
  input  logic [N_PER-1:0]   per_wr0,
  input  logic [N_PER-1:0]   per_stat_rd,
  input  logic [N_PER-1:0]   per_data_acc,
  output logic [N_PER-1:0]   per_flag,
  input  logic               mask_set,
  input  logic               mask_clr,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_mask,
  output logic               wake_wait,
  output logic               wake_halt
);
  logic             mask_q, trap_q, valid_q, take, any;
  logic [VEC_W-1:0] vec_q, sel;
  logic [N_EXT-1:0] ext_pend;
  logic [N_SRC-1:0] req, elig;

  assign take = valid_q & irq_ack;

  // Software trap latch: a new request in the accept cycle wins.
  always_ff @(posedge clk) begin
    if (!rst_n)                          trap_q <= 1'b0;
    else if (trap_req)                   trap_q <= 1'b1;
    else if (take && vec_q == '0)        trap_q <= 1'b0;
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    irq_ext_src #(.PINS(PINS_PER_EXT)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (ext_pin[i*PINS_PER_EXT +: PINS_PER_EXT]),
      .pin_en (ext_pin_en[i*PINS_PER_EXT +: PINS_PER_EXT]),
      .sense  (sense_e'(ext_sense[2*i +: 2])),
      .clr    (take && vec_q == VEC_W'(1 + i)),
      .pend   (ext_pend[i])
    );
    assign req[1+i] = ext_pend[i];
  end

  for (genvar j = 0; j < N_PER; j++) begin : g_per
    irq_per_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (per_set[j]),
      .wr0     (per_wr0[j]),
      .st_rd   (per_stat_rd[j]),
      .dat_acc (per_data_acc[j]),
      .flag    (per_flag[j])
    );
    assign req[1+N_EXT+j] = per_flag[j] & per_en[j];
  end

  assign req[0] = trap_q;
  assign elig   = req & {{(N_SRC-1){~mask_q}}, 1'b1};

  irq_prio_enc #(.N(N_SRC), .W(VEC_W)) u_enc (
    .req (elig),
    .any (any),
    .idx (sel)
  );

  // Offer register: loads when idle, holds until accepted,
  // withdraws a maskable offer once the mask is set.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (mask_q && vec_q != '0) valid_q <= 1'b0;
    end else begin
      valid_q <= any;
      vec_q   <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    mask_q <= 1'b1;
    else if (take || mask_set)     mask_q <= 1'b1;
    else if (irq_ret || mask_clr)  mask_q <= 1'b0;
  end

  assign irq_valid = valid_q;
  assign irq_vec   = vec_q;
  assign irq_mask  = mask_q;
  assign wake_wait = |req;
  assign wake_halt = |ext_pend;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_PER = 4,
  parameter int VEC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_PER-1:0] per_set,
  input logic [N_PER-1:0] per_wr0,
  input logic [N_PER-1:0] per_flag,
  input logic             mask_set,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic             irq_mask,
  input logic             wake_wait,
  input logic             wake_halt
);
  assert_entry_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> irq_mask);

  assert_return_unmasks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !(irq_valid && irq_ack) && !mask_set) |=> !irq_mask);

  assert_vec_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (!irq_valid || $stable(irq_vec)));

  assert_masked_offer_is_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && $past(irq_mask)) |-> (irq_vec == '0));

  assert_halt_wake_subset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_halt |-> wake_wait);

  for (genvar k = 0; k < N_PER; k++) begin : g_wr0
    assert_wr0_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (per_wr0[k] && !per_set[k]) |=> !per_flag[k]);
  end
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_PER(N_PER), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  localparam int NE = 2, PP = 2, NP = 4;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [NE*PP-1:0] ext_pin = '1;
  logic [NE*PP-1:0] ext_pin_en = '1;
  logic [2*NE-1:0] ext_sense = 4'b0101;
  logic [NP-1:0] per_set = '0, per_en = '0, per_wr0 = '0;
  logic [NP-1:0] per_stat_rd = '0, per_data_acc = '0;
  logic [NP-1:0] per_flag;
  logic mask_set = 1'b0, mask_clr = 1'b0;
  logic irq_valid, irq_ack = 1'b0, irq_ret = 1'b0, irq_mask;
  logic [VW-1:0] irq_vec;
  logic wake_wait, wake_halt;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl #(.N_EXT(NE), .PINS_PER_EXT(PP), .N_PER(NP)) u_dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic accept();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 mask", irq_mask, 1);
    check("R1 valid", irq_valid, 0);
    check("R1 flags", per_flag, 0);
    check("R1 wake_wait", wake_wait, 0);
    check("R1 wake_halt", wake_halt, 0);
  endtask

  task automatic t_masked_pending();
    ext_pin[0] = 1'b0;
    tick();
    check("R12 halt wake ext", wake_halt, 1);
    check("R12 wait wake ext", wake_wait, 1);
    tick(); tick();
    check("R2 held while masked", irq_valid, 0);
    ext_pin[0] = 1'b1;
    mask_clr = 1'b1; tick(); mask_clr = 1'b0;
    check("R3 mask_clr", irq_mask, 0);
    check("R14 not yet offered", irq_valid, 0);
    tick();
    check("R2 offered after unmask", irq_valid, 1);
    check("R2 vector", irq_vec, 1);
    accept();
    check("R3 accept drops valid", irq_valid, 0);
    check("R3 accept sets mask", irq_mask, 1);
    check("R6 edge latch cleared", wake_halt, 0);
    ret();
    check("R3 return clears mask", irq_mask, 0);
    tick();
    check("R6 not offered again", irq_valid, 0);
  endtask

  task automatic t_trap();
    mask_set = 1'b1; tick(); mask_set = 1'b0;
    check("R3 mask_set", irq_mask, 1);
    trap_req = 1'b1; tick(); trap_req = 1'b0;
    check("R14 trap one edge later", irq_valid, 0);
    tick();
    check("R4 trap offered masked", irq_valid, 1);
    check("R4 trap vector", irq_vec, 0);
    accept();
    ret();
  endtask

  task automatic t_priority();
    mask_set = 1'b1; tick(); mask_set = 1'b0;
    per_en[0] = 1'b1;
    per_set[0] = 1'b1; trap_req = 1'b1; ext_pin[2] = 1'b0;
    tick();
    per_set[0] = 1'b0; trap_req = 1'b0;
    tick();
    check("R5 trap first", irq_vec, 0);
    check("R5 trap valid", irq_valid, 1);
    accept();
    mask_clr = 1'b1; tick(); mask_clr = 1'b0;
    tick();
    check("R5 external next", irq_vec, 2);
    check("R5 external valid", irq_valid, 1);
    accept();
    ret();
    tick();
    check("R5 peripheral last", irq_vec, 3);
    check("R5 peripheral valid", irq_valid, 1);
    accept();
    per_wr0[0] = 1'b1; tick(); per_wr0[0] = 1'b0;
    check("R10 flag cleared by write", per_flag[0], 0);
    ret();
    tick();
    check("R10 request dropped", irq_valid, 0);
    ext_pin[2] = 1'b1;
    per_en[0] = 1'b0;
    tick();
  endtask

  task automatic t_level();
    ext_sense[3:2] = 2'b00;
    ext_pin[3] = 1'b0;
    tick();
    tick();
    check("R7 level offered", irq_valid, 1);
    check("R7 level vector", irq_vec, 2);
    accept();
    ret();
    tick();
    check("R6 level offered again", irq_valid, 1);
    ext_pin[3] = 1'b1;
    accept();
    ret();
    tick();
    check("R6 level released", irq_valid, 0);
    ext_sense[3:2] = 2'b01;
    tick();
  endtask

  task automatic t_rise_group();
    ext_sense[1:0] = 2'b10;
    ext_pin[0] = 1'b0; tick();
    ext_pin[1] = 1'b0; tick();
    ext_pin[1] = 1'b1; tick();
    tick();
    check("R8 low pin blocks rise", irq_valid, 0);
    check("R8 no halt wake", wake_halt, 0);
    ext_pin[0] = 1'b1; tick();
    check("R7 rise latched", wake_halt, 1);
    tick();
    check("R7 rise offered", irq_vec, 1);
    check("R7 rise valid", irq_valid, 1);
    accept();
    ret();
    ext_sense[1:0] = 2'b11;
    ext_pin[0] = 1'b0; tick();
    tick();
    check("R7 both: fall offered", irq_valid, 1);
    accept();
    ret();
    ext_pin[0] = 1'b1; tick();
    tick();
    check("R7 both: rise offered", irq_valid, 1);
    accept();
    ret();
    ext_sense[1:0] = 2'b01;
    tick();
  endtask

  task automatic t_per_enable();
    per_set[2] = 1'b1; tick(); per_set[2] = 1'b0;
    check("R9 flag set", per_flag[2], 1);
    check("R9 disabled no wake", wake_wait, 0);
    tick();
    check("R9 disabled not offered", irq_valid, 0);
    per_en[2] = 1'b1;
    #1;
    check("R12 enabled wakes wait", wake_wait, 1);
    check("R12 peripheral no halt", wake_halt, 0);
    tick();
    check("R9 offered when enabled", irq_valid, 1);
    check("R9 vector", irq_vec, 5);
    accept();
    per_wr0[2] = 1'b1; tick(); per_wr0[2] = 1'b0;
    ret();
    per_en[2] = 1'b0;
  endtask

  task automatic t_read_seq();
    per_set[1] = 1'b1; tick(); per_set[1] = 1'b0;
    per_data_acc[1] = 1'b1; tick(); per_data_acc[1] = 1'b0;
    check("R11 bare data access keeps flag", per_flag[1], 1);
    per_stat_rd[1] = 1'b1; tick(); per_stat_rd[1] = 1'b0;
    check("R11 read keeps flag", per_flag[1], 1);
    per_data_acc[1] = 1'b1; tick(); per_data_acc[1] = 1'b0;
    check("R11 sequence clears flag", per_flag[1], 0);
    per_en[1] = 1'b1; tick();
    check("R11 request lost", irq_valid, 0);
    per_en[1] = 1'b0;
  endtask

  task automatic t_withdraw();
    per_en[3] = 1'b1;
    per_set[3] = 1'b1; tick(); per_set[3] = 1'b0;
    tick();
    check("R13 offered", irq_vec, 6);
    trap_req = 1'b1; tick(); trap_req = 1'b0;
    tick();
    check("R13 vector held", irq_vec, 6);
    check("R13 valid held", irq_valid, 1);
    mask_set = 1'b1; tick(); mask_set = 1'b0;
    check("R13 still offered at mask edge", irq_valid, 1);
    tick();
    check("R13 withdrawn", irq_valid, 0);
    tick();
    check("R13 trap reoffered", irq_valid, 1);
    check("R13 trap vector", irq_vec, 0);
    accept();
    per_wr0[3] = 1'b1; tick(); per_wr0[3] = 1'b0;
    per_en[3] = 1'b0;
    ret();
  endtask

  initial begin
    t_reset();
    t_masked_pending();
    t_trap();
    t_priority();
    t_level();
    t_rise_group();
    t_per_enable();
    t_read_seq();
    t_withdraw();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule